// File: doc/BRIEF.md
# Descriptor Table Selector Resolution Unit

This block resolves a 16-bit segment selector into the linear address of the 8-byte descriptor it names. It holds two table registers. The global one carries a base and a limit. The local one caches a selector, base, limit and access-rights byte, so the local table can be reached without a lookup. Each request also carries a reference kind. The block checks the selector against the selected table's inclusive limit and applies the null-selector rules. It then answers with either a descriptor address or a general-protection fault, plus the matching error code. The global register can be read back as a 48-bit pseudo-descriptor.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel, registered one cycle after acceptance. The output stage holds one result. A new request is accepted only when that stage is empty or its result is being taken in the same cycle, so `req_ready` follows `rsp_ready` combinationally. A result that is not taken stays on the outputs unchanged. The table register loads are plain strobes with no handshake.

Top module: `dt_sel_resolver`

## Requirements
- R1: The selector is split into bits [15:3] index, bit [2] table select (0 = global table, 1 = local table) and bits [1:0] requested privilege level. A valid result has `rsp_addr` = selected base + index × 8, modulo 2^ADDR_W.
- R2: A non-null reference succeeds only if index × 8 + 7 ≤ the selected table's limit, with the limit inclusive. Otherwise the result is a fault.
- R3: On a fault, `rsp_err` equals the request selector with bits [1:0] cleared, and `rsp_addr` is 0. On success, `rsp_err` is 0.
- R4: A null selector is one with index 0 and table select 0. With kind 2'b00 (data-segment load) it succeeds with `rsp_null` = 1 and `rsp_addr` = global base, whatever the global limit.
- R5: A null selector with kind 2'b01 (code/stack load) or kind 2'b10 or 2'b11 (memory access) faults with error code 0.
- R6: A request with table select 1 faults while the cached local selector has bits [15:2] all zero.
- R7: A `gdt_ld` strobe writes the global base and limit. `gdt_pseudo` returns the limit in bits [15:0] and the base in bits [47:16].
- R8: An `ldt_ld` strobe writes the local selector, base, limit and attributes. `ldt_sel_rd` and `ldt_attr_rd` return the selector and attributes, and later local-table requests use the cached base and limit.
- R9: A request accepted on a clock edge produces a result with `rsp_valid` = 1 after that edge. While `rsp_valid` is 1, exactly one of `rsp_ok` and `rsp_fault` is 1.
- R10: `req_ready` is 1 exactly when `rsp_valid` is 0 or `rsp_ready` is 1. A result that is not taken stays unchanged, and results leave in request order.
- R11: After reset, `rsp_valid` is 0, `gdt_pseudo` is 0, and `ldt_sel_rd` and `ldt_attr_rd` are 0.
- R12: A request accepted on the same edge as a table load is resolved with the register contents from before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gdt_ld | input | 1 | Global table register write strobe |
| gdt_base_in | input | ADDR_W | Global base to write |
| gdt_lim_in | input | GLIM_W | Global limit to write (inclusive) |
| gdt_pseudo | output | GLIM_W+ADDR_W | Stored pseudo-descriptor {base, limit} |
| ldt_ld | input | 1 | Local table register write strobe |
| ldt_sel_in | input | 16 | Local table selector to cache |
| ldt_base_in | input | ADDR_W | Local base to cache |
| ldt_lim_in | input | LLIM_W | Local limit to cache (inclusive) |
| ldt_attr_in | input | ATTR_W | Local access rights to cache |
| ldt_sel_rd | output | 16 | Cached local selector |
| ldt_attr_rd | output | ATTR_W | Cached local access rights |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_sel | input | 16 | Selector to resolve |
| req_kind | input | 2 | 00 data load, 01 code/stack load, 1x memory access |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_ok | output | 1 | Descriptor reference is valid |
| rsp_fault | output | 1 | General-protection fault |
| rsp_null | output | 1 | Null selector loaded without fault |
| rsp_addr | output | ADDR_W | Descriptor linear address |
| rsp_err | output | 16 | Fault error code |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit global limit, a 20-bit local limit and 8-bit attributes. With these values, the highest 13-bit index ends exactly at byte 0xFFFF of a full global table, so the last-byte boundary can be hit on both sides. A base near the top of the address space can also be used to show that the address wraps. The wider local limit lies beyond anything a selector can reach, so every local fault in the bench comes from a limit set smaller on purpose or from a null local selector. A random consumer stall pattern is applied during a long mixed stream to exercise the hold and ordering rules.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int SEL_W   = 16;
  localparam int RPL_W   = 2;
  localparam int TI_BIT  = 2;
  localparam int IDX_LSB = 3;
  localparam int IDX_W   = SEL_W - IDX_LSB;
  localparam int DESC_SH = 3;

  typedef enum logic [1:0] {
    KIND_DATA  = 2'b00,
    KIND_CODE  = 2'b01,
    KIND_MEM   = 2'b10,
    KIND_MEM_B = 2'b11
  } ref_kind_e;
endpackage

// File: rtl/dt_table_regs.sv
module dt_table_regs #(
  parameter int ADDR_W = 32,
  parameter int GLIM_W = 16,
  parameter int LLIM_W = 20,
  parameter int ATTR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gdt_ld,
  input  logic [ADDR_W-1:0]        gdt_base_in,
  input  logic [GLIM_W-1:0]        gdt_lim_in,
  input  logic                     ldt_ld,
  input  logic [dt_pkg::SEL_W-1:0] ldt_sel_in,
  input  logic [ADDR_W-1:0]        ldt_base_in,
  input  logic [LLIM_W-1:0]        ldt_lim_in,
  input  logic [ATTR_W-1:0]        ldt_attr_in,
  output logic [ADDR_W-1:0]        gdt_base,
  output logic [GLIM_W-1:0]        gdt_lim,
  output logic [dt_pkg::SEL_W-1:0] ldt_sel,
  output logic [ADDR_W-1:0]        ldt_base,
  output logic [LLIM_W-1:0]        ldt_lim,
  output logic [ATTR_W-1:0]        ldt_attr,
  output logic                     ldt_null
);
  import dt_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gdt_base <= '0;
      gdt_lim  <= '0;
    end else if (gdt_ld) begin
      gdt_base <= gdt_base_in;
      gdt_lim  <= gdt_lim_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldt_sel  <= '0;
      ldt_base <= '0;
      ldt_lim  <= '0;
      ldt_attr <= '0;
    end else if (ldt_ld) begin
      ldt_sel  <= ldt_sel_in;
      ldt_base <= ldt_base_in;
      ldt_lim  <= ldt_lim_in;
      ldt_attr <= ldt_attr_in;
    end
  end

  // a cached local selector pointing at global entry 0 means no local table
  assign ldt_null = (ldt_sel[SEL_W-1:TI_BIT] == '0);
endmodule

// File: rtl/dt_sel_check.sv
module dt_sel_check #(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 20
) (
  input  logic [dt_pkg::SEL_W-1:0] sel,
  input  logic [1:0]               kind,
  input  logic [ADDR_W-1:0]        gbase,
  input  logic [LIM_W-1:0]         glim,
  input  logic [ADDR_W-1:0]        lbase,
  input  logic [LIM_W-1:0]         llim,
  input  logic                     lnull,
  output logic                     ok,
  output logic                     fault,
  output logic                     is_null,
  output logic [ADDR_W-1:0]        addr,
  output logic [dt_pkg::SEL_W-1:0] err
);
  import dt_pkg::*;

  localparam int END_W = IDX_W + DESC_SH;
  localparam int CMP_W = (END_W > LIM_W) ? END_W : LIM_W;

  logic [IDX_W-1:0]  idx;
  logic              ti;
  logic              sel_null;
  logic [END_W-1:0]  last_byte;
  logic [END_W-1:0]  first_byte;
  logic [ADDR_W-1:0] base_pick;
  logic [LIM_W-1:0]  lim_pick;
  logic              in_range;
  logic [SEL_W-1:0]  err_code;

  assign idx        = sel[SEL_W-1:IDX_LSB];
  assign ti         = sel[TI_BIT];
  assign sel_null   = !ti && (idx == '0);
  // last byte of an 8-byte entry: index with the three low bits all set
  assign last_byte  = {idx, {DESC_SH{1'b1}}};
  assign first_byte = {idx, {DESC_SH{1'b0}}};
  assign base_pick  = ti ? lbase : gbase;
  assign lim_pick   = ti ? llim  : glim;
  assign in_range   = CMP_W'(last_byte) <= CMP_W'(lim_pick);
  assign err_code   = sel & ~SEL_W'({RPL_W{1'b1}});

  always_comb begin
    ok      = 1'b0;
    fault   = 1'b0;
    is_null = 1'b0;
    addr    = '0;
    err     = '0;
    if (sel_null) begin
      if (kind == KIND_DATA) begin
        ok      = 1'b1;
        is_null = 1'b1;
        addr    = gbase;
      end else begin
        fault = 1'b1;
        err   = err_code;
      end
    end else if (ti && lnull) begin
      fault = 1'b1;
      err   = err_code;
    end else if (in_range) begin
      ok   = 1'b1;
      addr = base_pick + ADDR_W'(first_byte);
    end else begin
      fault = 1'b1;
      err   = err_code;
    end
  end
endmodule

// File: rtl/dt_rsp_stage.sv
module dt_rsp_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/dt_sel_resolver.sv
module dt_sel_resolver #(
  parameter int ADDR_W = 32,
  parameter int GLIM_W = 16,
  parameter int LLIM_W = 20,
  parameter int ATTR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gdt_ld,
  input  logic [ADDR_W-1:0]        gdt_base_in,
  input  logic [GLIM_W-1:0]        gdt_lim_in,
  output logic [GLIM_W+ADDR_W-1:0] gdt_pseudo,
  input  logic                     ldt_ld,
  input  logic [15:0]              ldt_sel_in,
  input  logic [ADDR_W-1:0]        ldt_base_in,
  input  logic [LLIM_W-1:0]        ldt_lim_in,
  input  logic [ATTR_W-1:0]        ldt_attr_in,
  output logic [15:0]              ldt_sel_rd,
  output logic [ATTR_W-1:0]        ldt_attr_rd,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [15:0]              req_sel,
  input  logic [1:0]               req_kind,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic                     rsp_ok,
  output logic                     rsp_fault,
  output logic                     rsp_null,
  output logic [ADDR_W-1:0]        rsp_addr,
  output logic [15:0]              rsp_err
);
  import dt_pkg::*;

  localparam int LIM_W = (GLIM_W > LLIM_W) ? GLIM_W : LLIM_W;
  localparam int PAY_W = 3 + ADDR_W + SEL_W;

  logic [ADDR_W-1:0] g_base, l_base;
  logic [GLIM_W-1:0] g_lim;
  logic [LLIM_W-1:0] l_lim;
  logic [SEL_W-1:0]  l_sel;
  logic [ATTR_W-1:0] l_attr;
  logic              l_null;

  dt_table_regs #(
    .ADDR_W(ADDR_W), .GLIM_W(GLIM_W), .LLIM_W(LLIM_W), .ATTR_W(ATTR_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .gdt_ld(gdt_ld), .gdt_base_in(gdt_base_in), .gdt_lim_in(gdt_lim_in),
    .ldt_ld(ldt_ld), .ldt_sel_in(ldt_sel_in), .ldt_base_in(ldt_base_in),
    .ldt_lim_in(ldt_lim_in), .ldt_attr_in(ldt_attr_in),
    .gdt_base(g_base), .gdt_lim(g_lim),
    .ldt_sel(l_sel), .ldt_base(l_base), .ldt_lim(l_lim), .ldt_attr(l_attr),
    .ldt_null(l_null)
  );

  assign gdt_pseudo  = {g_base, g_lim};
  assign ldt_sel_rd  = l_sel;
  assign ldt_attr_rd = l_attr;

  logic              c_ok, c_fault, c_null;
  logic [ADDR_W-1:0] c_addr;
  logic [SEL_W-1:0]  c_err;

  dt_sel_check #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) check_i (
    .sel(req_sel), .kind(req_kind),
    .gbase(g_base), .glim(LIM_W'(g_lim)),
    .lbase(l_base), .llim(LIM_W'(l_lim)),
    .lnull(l_null),
    .ok(c_ok), .fault(c_fault), .is_null(c_null),
    .addr(c_addr), .err(c_err)
  );

  logic [PAY_W-1:0] pay_in, pay_out;
  assign pay_in = {c_ok, c_fault, c_null, c_addr, c_err};

  dt_rsp_stage #(.W(PAY_W)) stage_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(pay_in),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(pay_out)
  );

  assign {rsp_ok, rsp_fault, rsp_null, rsp_addr, rsp_err} = pay_out;
endmodule

// File: rtl/dt_sel_resolver_chk.sv
module dt_sel_resolver_chk #(
  parameter int ADDR_W = 32,
  parameter int GLIM_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     gdt_ld,
  input logic [ADDR_W-1:0]        gdt_base_in,
  input logic [GLIM_W-1:0]        gdt_lim_in,
  input logic [GLIM_W+ADDR_W-1:0] gdt_pseudo,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic                     rsp_ok,
  input logic                     rsp_fault,
  input logic                     rsp_null,
  input logic [ADDR_W-1:0]        rsp_addr,
  input logic [15:0]              rsp_err
);
  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ok ^ rsp_fault));

  // R9
  accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
      $stable(rsp_err) && $stable(rsp_fault) && $stable(rsp_null)));

  // R3
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_err[1:0] == 2'b00 && rsp_addr == '0));

  // R4
  null_is_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_null) |-> (rsp_ok && rsp_err == '0));

  // R7
  pseudo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gdt_ld |=> (gdt_pseudo == {$past(gdt_base_in), $past(gdt_lim_in)}));
endmodule

bind dt_sel_resolver dt_sel_resolver_chk #(.ADDR_W(ADDR_W), .GLIM_W(GLIM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .gdt_ld(gdt_ld), .gdt_base_in(gdt_base_in),
  .gdt_lim_in(gdt_lim_in), .gdt_pseudo(gdt_pseudo),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_null(rsp_null),
  .rsp_addr(rsp_addr), .rsp_err(rsp_err)
);

// File: tb/dt_sel_resolver_tb_top.sv
`timescale 1ns/1ps
module dt_sel_resolver_tb_top;
  localparam int ADDR_W = 32;
  localparam int GLIM_W = 16;
  localparam int LLIM_W = 20;
  localparam int ATTR_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                     rst_n = 1'b0;
  logic                     gdt_ld = 1'b0;
  logic [ADDR_W-1:0]        gdt_base_in = '0;
  logic [GLIM_W-1:0]        gdt_lim_in = '0;
  logic [GLIM_W+ADDR_W-1:0] gdt_pseudo;
  logic                     ldt_ld = 1'b0;
  logic [15:0]              ldt_sel_in = '0;
  logic [ADDR_W-1:0]        ldt_base_in = '0;
  logic [LLIM_W-1:0]        ldt_lim_in = '0;
  logic [ATTR_W-1:0]        ldt_attr_in = '0;
  logic [15:0]              ldt_sel_rd;
  logic [ATTR_W-1:0]        ldt_attr_rd;
  logic                     req_valid = 1'b0;
  logic                     req_ready;
  logic [15:0]              req_sel = '0;
  logic [1:0]               req_kind = '0;
  logic                     rsp_valid;
  logic                     rsp_ready = 1'b1;
  logic                     rsp_ok, rsp_fault, rsp_null;
  logic [ADDR_W-1:0]        rsp_addr;
  logic [15:0]              rsp_err;

  dt_sel_resolver #(.ADDR_W(ADDR_W), .GLIM_W(GLIM_W), .LLIM_W(LLIM_W), .ATTR_W(ATTR_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .gdt_ld(gdt_ld), .gdt_base_in(gdt_base_in), .gdt_lim_in(gdt_lim_in), .gdt_pseudo(gdt_pseudo),
    .ldt_ld(ldt_ld), .ldt_sel_in(ldt_sel_in), .ldt_base_in(ldt_base_in),
    .ldt_lim_in(ldt_lim_in), .ldt_attr_in(ldt_attr_in),
    .ldt_sel_rd(ldt_sel_rd), .ldt_attr_rd(ldt_attr_rd),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault),
    .rsp_null(rsp_null), .rsp_addr(rsp_addr), .rsp_err(rsp_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic              ok, fault, nul;
    logic [ADDR_W-1:0] addr;
    logic [15:0]       err;
    string             tag;
  } exp_t;
  exp_t sb[$];

  // bench-side shadow of the table registers
  logic [31:0] sh_gbase = '0, sh_lbase = '0;
  logic [31:0] sh_glim = '0, sh_llim = '0;
  logic [15:0] sh_lsel = '0;

  function automatic exp_t model(logic [15:0] s, logic [1:0] k, string tag);
    exp_t e;
    logic [31:0] off, lim, base;
    e.ok = 0; e.fault = 0; e.nul = 0; e.addr = '0; e.err = '0; e.tag = tag;
    off = {16'h0, s[15:3], 3'b000};
    if (s[2] == 1'b0 && s[15:3] == 13'd0) begin
      if (k == 2'b00) begin e.ok = 1; e.nul = 1; e.addr = sh_gbase; end
      else begin e.fault = 1; e.err = 16'h0; end
    end else if (s[2] && sh_lsel[15:2] == 14'd0) begin
      e.fault = 1; e.err = {s[15:2], 2'b00};
    end else begin
      lim  = s[2] ? sh_llim : sh_glim;
      base = s[2] ? sh_lbase : sh_gbase;
      if (off + 32'd7 <= lim) begin e.ok = 1; e.addr = base + off; end
      else begin e.fault = 1; e.err = {s[15:2], 2'b00}; end
    end
    return e;
  endfunction

  task automatic check(bit cond, string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "unexpected result", 64'(rsp_addr), 64'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({rsp_ok, rsp_fault, rsp_null} == {e.ok, e.fault, e.nul} &&
              rsp_addr == e.addr && rsp_err == e.err, e.tag, "ok/fault/null/addr/err",
              {rsp_ok, rsp_fault, rsp_null, 13'h0, rsp_err, rsp_addr},
              {e.ok, e.fault, e.nul, 13'h0, e.err, e.addr});
      end
    end
  end

  // consumer back-pressure pattern
  bit bp_on = 1'b0;
  logic [15:0] bp_lfsr = 16'hACE1;
  always @(posedge clk) begin
    #2;
    bp_lfsr = {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
    rsp_ready = bp_on ? bp_lfsr[0] : 1'b1;
  end

  // R10 ready rule observed at the ports
  always @(negedge clk) begin
    if (rst_n && bp_on)
      check(req_ready == (!rsp_valid || rsp_ready), "R10", "req_ready",
            64'(req_ready), 64'(!rsp_valid || rsp_ready));
  end

  task automatic wait_accept();
    forever begin
      bit acc;
      acc = req_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
  endtask

  task automatic send(logic [15:0] s, logic [1:0] k, string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_sel = s; req_kind = k;
    e = model(s, k, tag);
    wait_accept();
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load_g(logic [31:0] b, logic [15:0] l);
    @(negedge clk);
    gdt_ld = 1'b1; gdt_base_in = b; gdt_lim_in = l;
    @(negedge clk);
    gdt_ld = 1'b0;
    sh_gbase = b; sh_glim = {16'h0, l};
  endtask

  task automatic load_l(logic [15:0] s, logic [31:0] b, logic [19:0] l, logic [7:0] a);
    @(negedge clk);
    ldt_ld = 1'b1; ldt_sel_in = s; ldt_base_in = b; ldt_lim_in = l; ldt_attr_in = a;
    @(negedge clk);
    ldt_ld = 1'b0;
    sh_lsel = s; sh_lbase = b; sh_llim = {12'h0, l};
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(rsp_valid == 1'b0, "R11", "rsp_valid", 64'(rsp_valid), 64'h0);
    check(gdt_pseudo == '0, "R11", "gdt_pseudo", 64'(gdt_pseudo), 64'h0);
    check(ldt_sel_rd == '0 && ldt_attr_rd == '0, "R11", "ldt_sel/attr",
          64'({ldt_sel_rd, ldt_attr_rd}), 64'h0);
    check(req_ready == 1'b1, "R10", "idle req_ready", 64'(req_ready), 64'h1);

    // R7 global load and pseudo-descriptor layout
    load_g(32'h0010_0000, 16'h00FF);
    check(gdt_pseudo == 48'h0010_0000_00FF, "R7", "gdt_pseudo",
          64'(gdt_pseudo), 64'h0010_0000_00FF);

    // R1 address, R2 boundary, R3 error code
    send(16'h0008, 2'b01, "R1 global idx1");
    send(16'h00FB, 2'b10, "R2 last entry in limit");
    send(16'h0103, 2'b01, "R3 idx32 out of limit");
    load_g(32'h0010_0000, 16'h00FE);
    send(16'h00F8, 2'b10, "R2 one byte short");

    // R4 / R5 null selector, even with a one-byte table
    load_g(32'h0040_0000, 16'h0000);
    send(16'h0000, 2'b00, "R4 null data load");
    send(16'h0003, 2'b00, "R4 null rpl3 data load");
    send(16'h0003, 2'b01, "R5 null code load");
    send(16'h0000, 2'b10, "R5 null memory access");
    send(16'h0002, 2'b11, "R5 null memory access alt");
    send(16'h0008, 2'b00, "R2 limit zero idx1");

    // R6 local reference with null local selector
    send(16'h000C, 2'b00, "R6 local while null");
    load_l(16'h0003, 32'h9000_0000, 20'hFFFFF, 8'h11);
    send(16'h0004, 2'b00, "R6 local sel idx0 rpl3");

    // R8 local load
    load_l(16'h0028, 32'h8000_0000, 20'h0003F, 8'h82);
    check(ldt_sel_rd == 16'h0028, "R8", "ldt_sel_rd", 64'(ldt_sel_rd), 64'h28);
    check(ldt_attr_rd == 8'h82, "R8", "ldt_attr_rd", 64'(ldt_attr_rd), 64'h82);
    send(16'h003F, 2'b01, "R8 local idx7");
    send(16'h0044, 2'b10, "R8 local idx8 fault");
    send(16'h0004, 2'b00, "R8 local idx0");

    // R1 address wrap at full global table
    load_g(32'hFFFF_FFF0, 16'hFFFF);
    send(16'hFFF8, 2'b01, "R1 top index wraps");
    send(16'hFFFE, 2'b10, "R2 local top index fault");
    drain();

    // R12 load in the same cycle as an accepted request
    begin
      exp_t e;
      @(negedge clk);
      gdt_ld = 1'b1; gdt_base_in = 32'h0000_2000; gdt_lim_in = 16'h0007;
      req_valid = 1'b1; req_sel = 16'h0010; req_kind = 2'b01;
      e = model(16'h0010, 2'b01, "R12 old table used");
      wait_accept();
      sb.push_back(e);
      @(negedge clk);
      gdt_ld = 1'b0; req_valid = 1'b0;
      sh_gbase = 32'h0000_2000; sh_glim = 32'h7;
    end
    send(16'h0010, 2'b01, "R12 new table used");
    drain();

    // R10 mixed stream under back-pressure, order kept
    load_g(32'h0002_0000, 16'h01FF);
    load_l(16'h0050, 32'h0300_0000, 20'h000FF, 8'h82);
    bp_on = 1'b1;
    begin
      logic [15:0] r = 16'h1D2B;
      for (int n = 0; n < 300; n++) begin
        r = r ^ (r << 7); r = r ^ (r >> 9); r = r ^ (r << 8);
        send({6'h0, r[9:0]}, r[11:10], "R10 stream");
      end
    end
    drain();
    bp_on = 1'b0;
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R10", "leftover results", 64'(sb.size()), 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule